// File: doc/BRIEF.md
# SCSI Host DMA Channel Controller

This block holds the registers and control of a bus-master DMA channel placed beside a SCSI protocol core. Host software writes a start byte count, a start memory address and a start descriptor-list address through a 32-bit register window, then writes a command word. The low two bits of that word select one of four operations. A start operation copies the three start values into working registers, clears the status flags and turns on the core's DMA enable.

While a transfer runs, the SCSI core asks for data chunks. For each chunk the channel limits the length to what remains in the working count. It then lowers the count and advances the working address by the granted length. A chunk whose direction disagrees with the direction bit in the command word is refused. When the core reports that its SCSI command has completed, the channel zeroes the working count and raises a done flag.

Status flags clear in one of two ways, chosen by bit 12 of a control word: writing ones to them, or reading them. The SCSI interrupt flag is not stored: it follows the core's live interrupt line. An interrupt output combines done and the SCSI interrupt, each gated by its own enable bit.

Top module: `scsi_dma_chan`

## Requirements
- R1: Writing the command word at 0x40 with bits [1:0] = 3 (start) copies the start count (0x44), start address (0x48) and start descriptor address (0x4C) into the working count (0x50), working address (0x54) and working descriptor address (0x5C).
- R2: A start command clears status bits 0x01, 0x02, 0x04, 0x08 and 0x20 of the status word (0x58) and sets `dma_en` on the next clock edge.
- R3: The operation in command bits [1:0] acts on every write to the command word. Op 0 (idle) clears `dma_en`. Op 2 (abort) raises `req_cancel` for exactly one cycle. Op 1 (blast) changes neither `dma_en` nor the status word.
- R4: Register access follows byte lanes. A write changes only the bytes whose `bus_be` bit is set. Read data carries only the enabled lanes and zeroes the others. Writes to the working registers at 0x50, 0x54 and 0x5C are ignored. Reads of the core range 0x00–0x3F return 0.
- R5: An accepted chunk is granted min(`xfer_len`, working count) bytes. The working count then drops by the grant and the working address rises by it. Once the count is 0, every grant is 0.
- R6: Command bit 7 set means device-to-memory. A chunk whose `xfer_to_mem` differs from that bit gives `xfer_err`=1, `xfer_ok`=0 and a grant of 0. It leaves the working count and address unchanged and sets status error bit 0x02.
- R7: A `core_done` pulse forces the working count to 0 and sets status done bit 0x08.
- R8: With control bit 12 (word at 0x70) clear, writing ones to status bits 0x02, 0x04 or 0x08 clears them. Zeros written leave them unchanged.
- R9: With control bit 12 set, writes to the status word are ignored. A status read returns the current flags and then clears 0x02, 0x04 and 0x08.
- R10: Status bit 0x10 reads as 1 exactly while `core_irq` is high.
- R11: `irq` = (done bit AND command bit 0x40) OR (`core_irq` AND command bit 0x20).
- R12: After reset: command word 0, working count 0, working address 0xFFFFFFFF, working descriptor address 0xFFFFFFFD, status 0, and `dma_en`, `req_cancel` and `irq` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 7 | Byte address within the register window |
| bus_be | input | 4 | Byte-lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, masked to the enabled lanes |
| core_irq | input | 1 | Live interrupt flag of the SCSI core |
| core_done | input | 1 | One-cycle pulse: SCSI command completed |
| xfer_req | input | 1 | Core requests a data chunk |
| xfer_to_mem | input | 1 | Chunk direction, 1 = device-to-memory |
| xfer_len | input | LEN_W | Requested chunk length in bytes |
| xfer_grant | output | LEN_W | Granted chunk length |
| xfer_ok | output | 1 | Chunk accepted |
| xfer_err | output | 1 | Chunk refused for direction mismatch |
| dma_en | output | 1 | DMA enable toward the core |
| req_cancel | output | 1 | One-cycle cancel of the current SCSI request |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the channel with a 12-bit count and an 8-bit chunk length. Each counter can then be driven to exhaustion within a few dozen chunks. This brings within reach both the grant clamping against a nearly empty count and the behaviour after the count reaches zero. The bench sweeps ten start counts, each followed by twenty-five chunk lengths spread over the 8-bit range. It derives every expected grant, count and address arithmetically. Both status-clearing modes, the direction refusal and the byte-lane merges are each run against hand-computed words.

// File: rtl/scsi_dma_pkg.sv
package scsi_dma_pkg;

    typedef enum logic [2:0] {
        RI_CMD  = 3'd0,
        RI_SCNT = 3'd1,
        RI_SADR = 3'd2,
        RI_SDSC = 3'd3,
        RI_WCNT = 3'd4,
        RI_WADR = 3'd5,
        RI_STAT = 3'd6,
        RI_WDSC = 3'd7
    } reg_idx_e;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_BLAST = 2'd1,
        OP_ABORT = 2'd2,
        OP_START = 2'd3
    } dma_op_e;

    localparam int CMD_DIR_BIT  = 7;
    localparam int CMD_DONE_IE  = 6;
    localparam int CMD_SINT_IE  = 5;
    localparam int ST_ERR       = 1;
    localparam int ST_ABT       = 2;
    localparam int ST_DONE      = 3;
    localparam int ST_SINT      = 4;
    localparam int CTRL_RDCLR   = 12;

    localparam logic [7:0] ST_START_CLR = 8'h3F;
    localparam logic [7:0] ST_EVT_MASK  = 8'h0E;

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic        dma_hit;
        logic        ctrl_hit;
        reg_idx_e    idx;
        logic [31:0] lanes;
    } bus_dec_t;

    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
        return m;
    endfunction

    function automatic logic [31:0] merge_lanes(input logic [31:0] cur,
                                                input logic [31:0] wd,
                                                input logic [31:0] m);
        return (cur & ~m) | (wd & m);
    endfunction

endpackage

// File: rtl/sdc_decode.sv
module sdc_decode
    import scsi_dma_pkg::*;
(
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [6:0]  bus_addr,
    input  logic [3:0]  bus_be,
    output bus_dec_t    dec
);
    always_comb begin
        dec.wr       = bus_wr;
        dec.rd       = bus_rd;
        dec.dma_hit  = (bus_addr[6:5] == 2'b10);
        dec.ctrl_hit = (bus_addr[6:2] == 5'b11100);
        dec.idx      = reg_idx_e'(bus_addr[4:2]);
        dec.lanes    = lane_mask(bus_be);
    end
endmodule

// File: rtl/sdc_xfer.sv
module sdc_xfer #(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CNT_W-1:0]  start_cnt,
    input  logic [ADDR_W-1:0] start_adr,
    input  logic [ADDR_W-1:0] start_dsc,
    input  logic              core_done,
    input  logic              dir_bit,
    input  logic              xfer_req,
    input  logic              xfer_to_mem,
    input  logic [LEN_W-1:0]  xfer_len,
    output logic [CNT_W-1:0]  w_cnt,
    output logic [ADDR_W-1:0] w_adr,
    output logic [ADDR_W-1:0] w_dsc,
    output logic [LEN_W-1:0]  xfer_grant,
    output logic              xfer_ok,
    output logic              xfer_err
);
    localparam logic [ADDR_W-1:0] ADR_RST = '1;
    localparam logic [ADDR_W-1:0] DSC_RST = ~ADDR_W'(2);

    logic [CNT_W-1:0] len_ext;
    logic [CNT_W-1:0] clamp;

    always_comb begin
        len_ext    = CNT_W'(xfer_len);
        clamp      = (len_ext > w_cnt) ? w_cnt : len_ext;
        xfer_ok    = xfer_req && (xfer_to_mem == dir_bit);
        xfer_err   = xfer_req && (xfer_to_mem != dir_bit);
        xfer_grant = xfer_ok ? LEN_W'(clamp) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            w_cnt <= '0;
            w_adr <= ADR_RST;
            w_dsc <= DSC_RST;
        end else if (load) begin
            w_cnt <= start_cnt;
            w_adr <= start_adr;
            w_dsc <= start_dsc;
        end else if (core_done) begin
            w_cnt <= '0;
        end else if (xfer_ok) begin
            w_cnt <= w_cnt - clamp;
            w_adr <= w_adr + ADDR_W'(clamp);
        end
    end
endmodule

// File: rtl/sdc_status.sv
module sdc_status
    import scsi_dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr_start,
    input  logic       wr_hit,
    input  logic [7:0] wr_bits,
    input  logic       rd_hit,
    input  logic       rdclr_mode,
    input  logic       set_err,
    input  logic       set_done,
    input  logic       core_irq,
    output logic [7:0] stat_q,
    output logic [7:0] stat_view
);
    logic [7:0] nxt;

    always_comb begin
        nxt = stat_q;
        if (clr_start) begin
            nxt = nxt & ~ST_START_CLR;
        end else if (rdclr_mode) begin
            if (rd_hit) nxt = nxt & ~ST_EVT_MASK;
        end else if (wr_hit) begin
            nxt = nxt & ~(wr_bits & ST_EVT_MASK);
        end
        if (set_err)  nxt[ST_ERR]  = 1'b1;
        if (set_done) nxt[ST_DONE] = 1'b1;
        nxt[ST_SINT] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= nxt;
    end

    always_comb begin
        stat_view          = stat_q;
        stat_view[ST_SINT] = core_irq;
    end
endmodule

// File: rtl/scsi_dma_chan.sv
module scsi_dma_chan
    import scsi_dma_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [6:0]       bus_addr,
    input  logic [3:0]       bus_be,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             core_irq,
    input  logic             core_done,
    input  logic             xfer_req,
    input  logic             xfer_to_mem,
    input  logic [LEN_W-1:0] xfer_len,
    output logic [LEN_W-1:0] xfer_grant,
    output logic             xfer_ok,
    output logic             xfer_err,
    output logic             dma_en,
    output logic             req_cancel,
    output logic             irq
);
    bus_dec_t          dec;
    logic [7:0]        cmd_q;
    logic [CNT_W-1:0]  scnt_q;
    logic [ADDR_W-1:0] sadr_q;
    logic [ADDR_W-1:0] sdsc_q;
    logic [31:0]       ctrl_q;
    logic [CNT_W-1:0]  w_cnt;
    logic [ADDR_W-1:0] w_adr;
    logic [ADDR_W-1:0] w_dsc;
    logic [7:0]        stat_q;
    logic [7:0]        stat_view;
    logic              cancel_q;
    logic              dma_en_q;

    logic        wr_dma, rd_dma, wr_ctrl;
    logic [31:0] cur_word, new_word, rd_word;
    dma_op_e     op;
    logic        op_start;

    sdc_decode u_dec (
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_be(bus_be), .dec(dec)
    );

    always_comb begin
        wr_dma  = dec.wr && dec.dma_hit;
        rd_dma  = dec.rd && dec.dma_hit;
        wr_ctrl = dec.wr && dec.ctrl_hit;
        case (dec.idx)
            RI_CMD:  cur_word = 32'(cmd_q);
            RI_SCNT: cur_word = 32'(scnt_q);
            RI_SADR: cur_word = 32'(sadr_q);
            RI_SDSC: cur_word = 32'(sdsc_q);
            RI_WCNT: cur_word = 32'(w_cnt);
            RI_WADR: cur_word = 32'(w_adr);
            RI_STAT: cur_word = 32'(stat_view);
            default: cur_word = 32'(w_dsc);
        endcase
        new_word = merge_lanes(wr_ctrl ? ctrl_q : cur_word, bus_wdata, dec.lanes);
        op       = dma_op_e'(new_word[1:0]);
        op_start = wr_dma && (dec.idx == RI_CMD) && (op == OP_START);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q    <= '0;
            scnt_q   <= '0;
            sadr_q   <= '0;
            sdsc_q   <= '0;
            ctrl_q   <= '0;
            dma_en_q <= 1'b0;
            cancel_q <= 1'b0;
        end else begin
            cancel_q <= 1'b0;
            if (wr_ctrl) ctrl_q <= new_word;
            if (wr_dma) begin
                case (dec.idx)
                    RI_CMD: begin
                        cmd_q <= new_word[7:0];
                        case (op)
                            OP_IDLE:  dma_en_q <= 1'b0;
                            OP_ABORT: cancel_q <= 1'b1;
                            OP_START: dma_en_q <= 1'b1;
                            default:  ;
                        endcase
                    end
                    RI_SCNT: scnt_q <= new_word[CNT_W-1:0];
                    RI_SADR: sadr_q <= new_word[ADDR_W-1:0];
                    RI_SDSC: sdsc_q <= new_word[ADDR_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    sdc_xfer #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_xfer (
        .clk(clk), .rst(rst), .load(op_start),
        .start_cnt(scnt_q), .start_adr(sadr_q), .start_dsc(sdsc_q),
        .core_done(core_done), .dir_bit(cmd_q[CMD_DIR_BIT]),
        .xfer_req(xfer_req), .xfer_to_mem(xfer_to_mem), .xfer_len(xfer_len),
        .w_cnt(w_cnt), .w_adr(w_adr), .w_dsc(w_dsc),
        .xfer_grant(xfer_grant), .xfer_ok(xfer_ok), .xfer_err(xfer_err)
    );

    sdc_status u_stat (
        .clk(clk), .rst(rst), .clr_start(op_start),
        .wr_hit(wr_dma && dec.idx == RI_STAT),
        .wr_bits(bus_wdata[7:0] & dec.lanes[7:0]),
        .rd_hit(rd_dma && dec.idx == RI_STAT),
        .rdclr_mode(ctrl_q[CTRL_RDCLR]),
        .set_err(xfer_err), .set_done(core_done), .core_irq(core_irq),
        .stat_q(stat_q), .stat_view(stat_view)
    );

    always_comb begin
        if (dec.dma_hit)       rd_word = cur_word;
        else if (dec.ctrl_hit) rd_word = ctrl_q;
        else                   rd_word = '0;
        bus_rdata = rd_word & dec.lanes;
    end

    assign dma_en     = dma_en_q;
    assign req_cancel = cancel_q;
    assign irq        = (stat_view[ST_DONE] & cmd_q[CMD_DONE_IE])
                      | (stat_view[ST_SINT] & cmd_q[CMD_SINT_IE]);
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker #(
    parameter int CNT_W = 24,
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic             core_done,
    input logic             core_irq,
    input logic             xfer_req,
    input logic             xfer_ok,
    input logic             xfer_err,
    input logic [LEN_W-1:0] xfer_len,
    input logic [LEN_W-1:0] xfer_grant,
    input logic [CNT_W-1:0] w_cnt,
    input logic             done_bit,
    input logic             dma_en,
    input logic             req_cancel,
    input logic             irq
);
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!dma_en && !req_cancel && w_cnt == '0)); // R12

    AST_GRANT_BOUND: assert property (@(posedge clk) disable iff (rst)
        xfer_ok |-> (CNT_W'(xfer_grant) <= w_cnt && xfer_grant <= xfer_len)); // R5

    AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && xfer_err && !core_done && !bus_wr) |=> $stable(w_cnt)); // R6

    AST_REJECT_NOGRANT: assert property (@(posedge clk) disable iff (rst)
        xfer_err |-> (xfer_grant == '0 && !xfer_ok)); // R6

    AST_DONE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (core_done && !bus_wr) |=> (w_cnt == '0 && done_bit)); // R7

    AST_CANCEL_PULSE: assert property (@(posedge clk) disable iff (rst)
        req_cancel |=> !req_cancel); // R3

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (core_irq || done_bit)); // R11
endmodule

bind scsi_dma_chan sdc_checker #(.CNT_W(CNT_W), .LEN_W(LEN_W)) chk_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .core_done(core_done),
    .core_irq(core_irq), .xfer_req(xfer_req), .xfer_ok(xfer_ok),
    .xfer_err(xfer_err), .xfer_len(xfer_len), .xfer_grant(xfer_grant),
    .w_cnt(w_cnt), .done_bit(stat_q[3]), .dma_en(dma_en),
    .req_cancel(req_cancel), .irq(irq)
);

// File: tb/scsi_dma_chan_tb.sv
module scsi_dma_chan_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W  = 12;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 8;

    localparam logic [6:0] A_CMD = 7'h40, A_SCNT = 7'h44, A_SADR = 7'h48,
        A_SDSC = 7'h4C, A_WCNT = 7'h50, A_WADR = 7'h54, A_STAT = 7'h58,
        A_WDSC = 7'h5C, A_CTRL = 7'h70;

    logic clk = 0, rst = 1;
    logic bus_wr = 0, bus_rd = 0;
    logic [6:0] bus_addr = '0;
    logic [3:0] bus_be = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic core_irq = 0, core_done = 0, xfer_req = 0, xfer_to_mem = 0;
    logic [LEN_W-1:0] xfer_len = '0, xfer_grant;
    logic xfer_ok, xfer_err, dma_en, req_cancel, irq;

    int compared = 0, mismatched = 0;
    logic [31:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    scsi_dma_chan #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .core_irq(core_irq), .core_done(core_done),
        .xfer_req(xfer_req), .xfer_to_mem(xfer_to_mem), .xfer_len(xfer_len),
        .xfer_grant(xfer_grant), .xfer_ok(xfer_ok), .xfer_err(xfer_err),
        .dma_en(dma_en), .req_cancel(req_cancel), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr = 0; bus_be = '0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_rd = 1; bus_addr = a; bus_be = be;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 0; bus_be = '0;
    endtask

    task automatic chunk(input logic to_mem, input logic [LEN_W-1:0] len,
                         output logic [LEN_W-1:0] g, output logic ok, output logic er);
        @(negedge clk);
        xfer_req = 1; xfer_to_mem = to_mem; xfer_len = len;
        #1 g = xfer_grant; ok = xfer_ok; er = xfer_err;
        @(negedge clk);
        xfer_req = 0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        core_done = 1;
        @(negedge clk);
        core_done = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [LEN_W-1:0] g;
        logic ok, er;
        int ec, ea, exp_g;

        repeat (3) @(negedge clk);
        rst = 0;

        // R12 reset state
        rd(A_CMD, rv);  check("R12 cmd", rv, 32'h0);
        rd(A_WCNT, rv); check("R12 wcnt", rv, 32'h0);
        rd(A_WADR, rv); check("R12 wadr", rv, 32'hFFFF_FFFF);
        rd(A_WDSC, rv); check("R12 wdsc", rv, 32'hFFFF_FFFD);
        rd(A_STAT, rv); check("R12 stat", rv, 32'h0);
        check("R12 dma_en", {31'b0, dma_en}, 0);
        check("R12 irq", {31'b0, irq}, 0);

        // R1 start snapshot
        wr(A_SCNT, 32'h0000_0ABC);
        wr(A_SADR, 32'h8000_1000);
        wr(A_SDSC, 32'h4000_0040);
        wr(A_CMD, 32'h0000_0083);
        rd(A_WCNT, rv); check("R1 wcnt", rv, 32'h0ABC);
        rd(A_WADR, rv); check("R1 wadr", rv, 32'h8000_1000);
        rd(A_WDSC, rv); check("R1 wdsc", rv, 32'h4000_0040);
        check("R2 dma_en", {31'b0, dma_en}, 1);

        // R4 byte lanes, read-only working regs, core range
        wr(A_SADR, 32'h1122_3344);
        wr(A_SADR, 32'h00AA_0000, 4'b0100);
        rd(A_SADR, rv); check("R4 merge", rv, 32'h11AA_3344);
        rd(A_SADR, rv, 4'b0001); check("R4 lane read", rv, 32'h0000_0044);
        wr(A_WCNT, 32'h0000_0123);
        rd(A_WCNT, rv); check("R4 wcnt ro", rv, 32'h0ABC);
        wr(A_WADR, 32'h0);
        rd(A_WADR, rv); check("R4 wadr ro", rv, 32'h8000_1000);
        rd(7'h08, rv); check("R4 core range", rv, 32'h0);

        // R5 sweep of counts and chunk lengths (direction device-to-memory)
        for (int si = 0; si < 10; si++) begin
            ec = (si * 911 + 5) % 4096;
            if (si == 1) ec = 0;
            if (si == 2) ec = 1;
            ea = 32'h1000_0000 + si * 256;
            wr(A_SCNT, ec);
            wr(A_SADR, ea);
            wr(A_CMD, 32'h0000_0083);
            for (int k = 0; k < 25; k++) begin
                int len;
                len = (k * 29 + si * 7 + 3) % 256;
                exp_g = (len < ec) ? len : ec;
                chunk(1'b1, LEN_W'(len), g, ok, er);
                check("R5 grant", 32'(g), exp_g);
                check("R5 ok", {31'b0, ok}, 1);
                ec = ec - exp_g;
                ea = ea + exp_g;
            end
            rd(A_WCNT, rv); check("R5 wcnt", rv, ec);
            rd(A_WADR, rv); check("R5 wadr", rv, ea);
        end

        // R6 direction mismatch
        wr(A_SCNT, 32'h100);
        wr(A_SADR, 32'h2000);
        wr(A_CMD, 32'h0000_0083);
        chunk(1'b0, 8'd16, g, ok, er);
        check("R6 err", {31'b0, er}, 1);
        check("R6 ok", {31'b0, ok}, 0);
        check("R6 grant", 32'(g), 0);
        rd(A_WCNT, rv); check("R6 wcnt", rv, 32'h100);
        rd(A_WADR, rv); check("R6 wadr", rv, 32'h2000);
        rd(A_STAT, rv); check("R6 stat err", rv, 32'h02);

        // R8 write-one-to-clear mode
        wr(A_STAT, 32'h0);
        rd(A_STAT, rv); check("R8 zero write keeps", rv, 32'h02);
        wr(A_STAT, 32'h02);
        rd(A_STAT, rv); check("R8 w1c", rv, 32'h0);

        // R2 start clears status
        chunk(1'b0, 8'd4, g, ok, er);
        wr(A_CMD, 32'h0000_0083);
        rd(A_STAT, rv); check("R2 clear", rv, 32'h0);

        // R7 completion
        pulse_done();
        rd(A_WCNT, rv); check("R7 wcnt", rv, 32'h0);
        rd(A_STAT, rv); check("R7 done", rv, 32'h08);

        // R9 read-clear mode
        wr(A_CTRL, 32'h0000_1000);
        wr(A_STAT, 32'h0E);
        rd(A_STAT, rv); check("R9 write ignored", rv, 32'h08);
        rd(A_STAT, rv); check("R9 read cleared", rv, 32'h0);
        wr(A_CTRL, 32'h0);

        // R10 live interrupt mirror
        @(negedge clk) core_irq = 1;
        rd(A_STAT, rv); check("R10 sint on", rv, 32'h10);
        @(negedge clk) core_irq = 0;
        rd(A_STAT, rv); check("R10 sint off", rv, 32'h0);

        // R3 blast keeps dma_en and status (direction bit 7, done enable 0x40)
        pulse_done();
        wr(A_CMD, 32'h0000_00C1);
        check("R3 blast dma_en", {31'b0, dma_en}, 1);
        rd(A_STAT, rv); check("R3 blast stat", rv, 32'h08);

        // R11 interrupt combining
        #1 check("R11 done irq", {31'b0, irq}, 1);
        wr(A_CMD, 32'h0000_0021);
        #1 check("R11 masked", {31'b0, irq}, 0);
        @(negedge clk) core_irq = 1;
        #1 check("R11 sint irq", {31'b0, irq}, 1);
        @(negedge clk) core_irq = 0;

        // R3 abort and idle
        wr(A_CMD, 32'h0000_0002);
        check("R3 cancel high", {31'b0, req_cancel}, 1);
        @(negedge clk);
        check("R3 cancel one cycle", {31'b0, req_cancel}, 0);
        check("R3 abort keeps dma_en", {31'b0, dma_en}, 1);
        wr(A_CMD, 32'h0000_0000);
        check("R3 idle", {31'b0, dma_en}, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule